// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller. Its pins are grouped into banks of 32. Every bank has its own set of registers. Software programs the direction of each pin. It changes output levels through separate write-one-to-set and write-one-to-clear words, so a read-modify-write is never needed. It reads back the synchronized level of every pin.

Every pin can also watch for rising edges, falling edges or both. A detected edge latches into a sticky status bit. That bit stays set until software writes a one to it. A per-bank mask decides which status bits reach the processor. All unmasked status bits are merged into one combined interrupt. The first two pins of bank 0 also drive dedicated interrupt lines.

Banks sit in the address map in groups of three. Within a 256-byte window, the three banks of a group are interleaved word by word. The next group starts at the next 256-byte boundary. The bus port takes single-cycle writes and registered reads.

Top module: `gpio_banked`

## Requirements
- R1: Bank n decodes at byte address ((n / 3) * 0x100) + ((n % 3) * 4) + offset. The offsets within a bank are level 0x00, direction 0x0C, output-set 0x18, output-clear 0x24, rising-enable 0x30, falling-enable 0x3C, edge-status 0x48 and interrupt-mask 0x9C. Bit i of every register belongs to pin i of that bank, which is pin 32*n+i on the pin vectors.
- R2: After reset, the direction, output, edge-enable, edge-status and mask registers are all zero. `pin_oe`, `pin_out`, `bus_rdata` and all three interrupt outputs are low.
- R3: A write to output-set drives high every output whose data bit is 1. Outputs whose data bit is 0 keep their value.
- R4: A write to output-clear drives low every output whose data bit is 1. Outputs whose data bit is 0 keep their value.
- R5: Direction bit 1 makes a pin an output (`pin_oe` high) and bit 0 makes it an input. The direction register reads back what was written.
- R6: The level register returns each pin's input after a two-flop synchronizer, whatever that pin's direction is. A change on `pin_in` is visible in a read issued three clock edges later.
- R7: With its rising-enable bit set, a 0-to-1 transition of the synchronized input sets the pin's edge-status bit. With rising-enable clear, such a transition leaves the bit unchanged.
- R8: With its falling-enable bit set, a 1-to-0 transition sets the pin's edge-status bit. With both enables set, either transition sets it.
- R9: Edge-status bits are sticky. Writing 1 to a bit clears it and writing 0 leaves it. Writing all ones clears the whole bank.
- R10: If a clearing write and a new edge hit the same status bit in the same cycle, the bit ends up set.
- R11: `irq_any` goes high, one cycle after the status register, when any bank has a status bit whose mask bit is 1. Masked status bits do not raise it.
- R12: `irq_pin0` and `irq_pin1` follow the masked edge status of bank 0 pins 0 and 1, with the same registered timing as `irq_any`.
- R13: Reads return zero for unmapped offsets, for banks beyond NUM_BANKS, and for the write-only set and clear registers. A read returns its data on `bus_rdata` one cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pin_in | input | NUM_BANKS*DATA_W | Asynchronous pin inputs |
| pin_out | output | NUM_BANKS*DATA_W | Output levels |
| pin_oe | output | NUM_BANKS*DATA_W | Output enables (direction) |
| irq_any | output | 1 | Combined masked edge interrupt |
| irq_pin0 | output | 1 | Dedicated interrupt of pin 0 |
| irq_pin1 | output | 1 | Dedicated interrupt of pin 1 |

## Verification
The assertions assume a few things about the inputs. `bus_wr` and `bus_rd` are never asserted in the same cycle. Addresses are word aligned whenever a write must land. Reset is held long enough to flush the synchronizer.

The stimulus drives the bus and the pins only at falling clock edges. It issues one access per strobe. It changes `pin_in` only while the bus is idle, except in the collision case, where a clearing write is placed deliberately in the cycle the edge latches.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [3:0] {
    RK_LEVEL = 4'd0,
    RK_DIR   = 4'd1,
    RK_SET   = 4'd2,
    RK_CLR   = 4'd3,
    RK_RISE  = 4'd4,
    RK_FALL  = 4'd5,
    RK_STAT  = 4'd6,
    RK_MASK  = 4'd7,
    RK_NONE  = 4'd8
  } reg_kind_e;

  localparam int BANKS_PER_GROUP = 3;
  localparam int NUM_STRIDED     = 7;   // kinds laid out at 3-word strides
  localparam int MASK_WORD       = 39;  // byte offset 0x9C / 4

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_BANKS = 4,
  parameter int BIDX_W    = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [BIDX_W-1:0] bank,
  output logic              hit
);
  always_comb begin
    int word;
    int grp;
    int sub;
    int bidx;
    kind = RK_NONE;
    sub  = 0;
    word = int'(addr[7:2]);
    grp  = int'(addr[ADDR_W-1:8]);
    for (int k = 0; k < NUM_STRIDED; k++) begin
      if (word >= BANKS_PER_GROUP*k && word < BANKS_PER_GROUP*(k+1)) begin
        kind = reg_kind_e'(4'(k));
        sub  = word - BANKS_PER_GROUP*k;
      end
    end
    if (word >= MASK_WORD && word < MASK_WORD + BANKS_PER_GROUP) begin
      kind = RK_MASK;
      sub  = word - MASK_WORD;
    end
    if (addr[1:0] != 2'b00) kind = RK_NONE;
    bidx = grp*BANKS_PER_GROUP + sub;
    hit  = (kind != RK_NONE) && (bidx < NUM_BANKS);
    bank = BIDX_W'(bidx);
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_async,
  input  logic         wr_en,
  input  reg_kind_e    wr_kind,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] level,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] out_q,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] mask_q
);
  logic [W-1:0] prev_q;
  logic [W-1:0] edge_hit;
  logic [W-1:0] clr_bits;

  gpio_sync2 #(.W(W)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_async),
    .q   (level)
  );

  assign edge_hit = (level & ~prev_q & rise_q) | (~level & prev_q & fall_q);
  assign clr_bits = (wr_en && wr_kind == RK_STAT) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      prev_q <= level;
      // a fresh edge outranks a clear landing in the same cycle
      stat_q <= (stat_q & ~clr_bits) | edge_hit;
      if (wr_en) begin
        case (wr_kind)
          RK_DIR:  dir_q  <= wdata;
          RK_SET:  out_q  <= out_q | wdata;
          RK_CLR:  out_q  <= out_q & ~wdata;
          RK_RISE: rise_q <= wdata;
          RK_FALL: fall_q <= wdata;
          RK_MASK: mask_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_kind == RK_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R9

  AST_EDGE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ~$past(stat_q)) & ~($past(rise_q) | $past(fall_q))) == '0); // R7

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_kind == RK_SET) |=> ((out_q & $past(wdata)) == $past(wdata))); // R3

  AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_kind == RK_CLR) |=> ((out_q & $past(wdata)) == '0)); // R4

  AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_kind == RK_DIR) |=> $stable(dir_q)); // R5

endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  input  logic [NUM_BANKS*DATA_W-1:0]   pin_in,
  output logic [NUM_BANKS*DATA_W-1:0]   pin_out,
  output logic [NUM_BANKS*DATA_W-1:0]   pin_oe,
  output logic                          irq_any,
  output logic                          irq_pin0,
  output logic                          irq_pin1
);
  localparam int BIDX_W = $clog2(NUM_BANKS + 1);

  reg_kind_e         dec_kind;
  logic [BIDX_W-1:0] dec_bank;
  logic              dec_hit;

  logic [DATA_W-1:0] lvl_a  [NUM_BANKS];
  logic [DATA_W-1:0] dir_a  [NUM_BANKS];
  logic [DATA_W-1:0] out_a  [NUM_BANKS];
  logic [DATA_W-1:0] rise_a [NUM_BANKS];
  logic [DATA_W-1:0] fall_a [NUM_BANKS];
  logic [DATA_W-1:0] stat_a [NUM_BANKS];
  logic [DATA_W-1:0] mask_a [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_pend;
  logic [DATA_W-1:0] rd_word;

  gpio_addr_dec #(
    .ADDR_W    (ADDR_W),
    .NUM_BANKS (NUM_BANKS),
    .BIDX_W    (BIDX_W)
  ) i_dec (
    .addr (bus_addr),
    .kind (dec_kind),
    .bank (dec_bank),
    .hit  (dec_hit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = bus_wr && dec_hit && (dec_bank == BIDX_W'(b));

    gpio_bank #(.W(DATA_W)) i_bank (
      .clk       (clk),
      .rst       (rst),
      .pin_async (pin_in[b*DATA_W +: DATA_W]),
      .wr_en     (bank_wr),
      .wr_kind   (dec_kind),
      .wdata     (bus_wdata),
      .level     (lvl_a[b]),
      .dir_q     (dir_a[b]),
      .out_q     (out_a[b]),
      .rise_q    (rise_a[b]),
      .fall_q    (fall_a[b]),
      .stat_q    (stat_a[b]),
      .mask_q    (mask_a[b])
    );

    assign pin_out[b*DATA_W +: DATA_W] = out_a[b];
    assign pin_oe [b*DATA_W +: DATA_W] = dir_a[b];
    assign bank_pend[b] = |(stat_a[b] & mask_a[b]);
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (dec_hit && dec_bank == BIDX_W'(b)) begin
        case (dec_kind)
          RK_LEVEL: rd_word = lvl_a[b];
          RK_DIR:   rd_word = dir_a[b];
          RK_RISE:  rd_word = rise_a[b];
          RK_FALL:  rd_word = fall_a[b];
          RK_STAT:  rd_word = stat_a[b];
          RK_MASK:  rd_word = mask_a[b];
          default:  rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_any   <= 1'b0;
      irq_pin0  <= 1'b0;
      irq_pin1  <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_word;
      irq_any  <= |bank_pend;
      irq_pin0 <= stat_a[0][0] & mask_a[0][0];
      irq_pin1 <= stat_a[0][1] & mask_a[0][1];
    end
  end

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !dec_hit) |=> (bus_rdata == '0)); // R13

  AST_PIN0_IMPLIES_ANY: assert property (@(posedge clk) disable iff (rst)
    irq_pin0 |-> irq_any); // R12

  AST_PIN1_IMPLIES_ANY: assert property (@(posedge clk) disable iff (rst)
    irq_pin1 |-> irq_any); // R12

  AST_NO_IRQ_WHEN_MASKED: assert property (@(posedge clk) disable iff (rst)
    (bank_pend == '0) |=> !irq_any); // R11

endmodule

// File: tb/test_gpio_banked.sv
module test_gpio_banked;
  localparam int  NB     = 4;
  localparam int  AW     = 12;
  localparam int  DW     = 32;
  localparam time CLK_PERIOD = 10ns;

  localparam int OFF_LVL  = 'h00;
  localparam int OFF_DIR  = 'h0C;
  localparam int OFF_SET  = 'h18;
  localparam int OFF_CLR  = 'h24;
  localparam int OFF_RISE = 'h30;
  localparam int OFF_FALL = 'h3C;
  localparam int OFF_STAT = 'h48;
  localparam int OFF_MASK = 'h9C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NB*DW-1:0] pin_in = '0;
  logic [NB*DW-1:0] pin_out;
  logic [NB*DW-1:0] pin_oe;
  logic irq_any, irq_pin0, irq_pin1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_banked #(.NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW)) i_gpio_banked (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_any(irq_any), .irq_pin0(irq_pin0), .irq_pin1(irq_pin1)
  );

  function automatic logic [AW-1:0] ra(int b, int off);
    return AW'(((b / 3) << 8) + ((b % 3) << 2) + off);
  endfunction

  function automatic logic [DW-1:0] pat(int b, int k);
    return DW'(32'h9E3779B9 * (b*7 + k + 1)) ^ DW'(k << 3);
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic [DW-1:0] exp_out [NB];
    logic [DW-1:0] exp_stat;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R2: reset state at the ports and in every register
    chk("R2 pin_out", DW'(|pin_out), '0);
    chk("R2 pin_oe",  DW'(|pin_oe),  '0);
    chk("R2 irqs",    DW'({irq_any, irq_pin0, irq_pin1}), '0);
    chk("R2 rdata",   bus_rdata, '0);
    for (int b = 0; b < NB; b++) begin
      rd(ra(b, OFF_DIR),  d); chk("R2 dir",  d, '0);
      rd(ra(b, OFF_STAT), d); chk("R2 stat", d, '0);
      rd(ra(b, OFF_MASK), d); chk("R2 mask", d, '0);
      exp_out[b] = '0;
    end

    // R1 R5: direction per bank through the interleaved map
    for (int b = 0; b < NB; b++) wr(ra(b, OFF_DIR), pat(b, 0));
    for (int b = 0; b < NB; b++) begin
      rd(ra(b, OFF_DIR), d); chk("R1 R5 dir readback", d, pat(b, 0));
      chk("R5 pin_oe", pin_oe[b*DW +: DW], pat(b, 0));
    end

    // R3 R4: set / clear sweeps
    for (int k = 1; k < 5; k++) begin
      for (int b = 0; b < NB; b++) begin
        wr(ra(b, OFF_SET), pat(b, k));
        exp_out[b] = exp_out[b] | pat(b, k);
        chk("R3 set", pin_out[b*DW +: DW], exp_out[b]);
        wr(ra(b, OFF_CLR), pat(b, k+10));
        exp_out[b] = exp_out[b] & ~pat(b, k+10);
        chk("R4 clear", pin_out[b*DW +: DW], exp_out[b]);
      end
    end
    wr(ra(1, OFF_SET), '0);
    chk("R3 zero word keeps", pin_out[DW +: DW], exp_out[1]);
    wr(ra(1, OFF_CLR), '0);
    chk("R4 zero word keeps", pin_out[DW +: DW], exp_out[1]);

    // R6: level follows the synchronized pins, outputs or not
    for (int b = 0; b < NB; b++) pin_in[b*DW +: DW] = pat(b, 20);
    settle(4);
    for (int b = 0; b < NB; b++) begin
      rd(ra(b, OFF_LVL), d); chk("R6 level", d, pat(b, 20));
    end
    @(negedge clk);
    pin_in[DW +: DW] = ~pat(1, 20);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ra(1, OFF_LVL);
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R6 two-flop latency", bus_rdata, pat(1, 20));
    settle(3);
    rd(ra(1, OFF_LVL), d); chk("R6 level after sync", d, ~pat(1, 20));

    // R7 R8 R9: edge detection per bank
    pin_in = '0;
    settle(4);
    for (int b = 0; b < NB; b++) wr(ra(b, OFF_STAT), '1);
    for (int b = 0; b < NB; b++) begin
      wr(ra(b, OFF_RISE), 32'h0000FFFF);
      wr(ra(b, OFF_FALL), 32'hFF00FF00);
      pin_in[b*DW +: DW] = '1;
      settle(4);
      rd(ra(b, OFF_STAT), d); chk("R7 rising edges", d, 32'h0000FFFF);
      pin_in[b*DW +: DW] = '0;
      settle(4);
      rd(ra(b, OFF_STAT), d); chk("R8 falling and both", d, 32'hFF00FFFF);
      wr(ra(b, OFF_STAT), 32'h00F0000F);
      rd(ra(b, OFF_STAT), d); chk("R9 partial clear", d, 32'hFF00FFF0);
      wr(ra(b, OFF_STAT), '1);
      rd(ra(b, OFF_STAT), d); chk("R9 full clear", d, '0);
    end

    // R10: clear and new edge in the same cycle
    wr(ra(0, OFF_RISE), 32'h00000080);
    wr(ra(0, OFF_FALL), '0);
    @(negedge clk); pin_in[7] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ra(0, OFF_STAT); bus_wdata = 32'h00000080;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(ra(0, OFF_STAT), d); chk("R10 edge beats clear", d, 32'h00000080);
    wr(ra(0, OFF_STAT), '1);
    pin_in = '0;
    settle(4);

    // R11: masked status stays quiet; unmasked raises the combined line
    wr(ra(3, OFF_RISE), 32'h00000020);
    pin_in[3*DW + 5] = 1'b1;
    settle(5);
    chk("R11 masked quiet", DW'(irq_any), '0);
    wr(ra(3, OFF_MASK), 32'h00000020);
    settle(2);
    chk("R11 unmasked any", DW'(irq_any), 1);
    chk("R12 pin0 idle", DW'({irq_pin0, irq_pin1}), '0);
    wr(ra(3, OFF_STAT), 32'h00000020);
    settle(2);
    chk("R11 cleared any", DW'(irq_any), '0);

    // R12: dedicated lines of pins 0 and 1
    wr(ra(0, OFF_MASK), '1);
    rd(ra(0, OFF_MASK), d); chk("R1 mask readback", d, '1);
    wr(ra(0, OFF_RISE), 32'h00000003);
    pin_in[0] = 1'b1;
    settle(5);
    chk("R12 pin0 line", DW'({irq_any, irq_pin0, irq_pin1}), 32'h6);
    pin_in[1] = 1'b1;
    settle(5);
    chk("R12 pin1 line", DW'({irq_any, irq_pin0, irq_pin1}), 32'h7);
    wr(ra(0, OFF_STAT), 32'h1);
    settle(2);
    chk("R12 pin0 cleared", DW'({irq_any, irq_pin0, irq_pin1}), 32'h5);

    // R13: unmapped offsets, absent banks, write-only words
    rd(ra(0, 'h60), d);     chk("R13 hole", d, '0);
    rd(ra(4, OFF_DIR), d);  chk("R13 absent bank", d, '0);
    rd(ra(2, OFF_SET), d);  chk("R13 set write-only", d, '0);
    rd(ra(2, OFF_CLR), d);  chk("R13 clear write-only", d, '0);
    rd(AW'(ra(0, OFF_DIR) + 1), d); chk("R13 misaligned", d, '0);
    wr(ra(4, OFF_DIR), '1);
    exp_stat = '0;
    for (int b = 0; b < NB; b++) begin
      rd(ra(b, OFF_DIR), d); chk("R13 absent-bank write ignored", d, pat(b, 0));
    end
    chk("R13 no stray", exp_stat, '0);

    done = 1'b1;
    summary();
  end
endmodule